// File: doc/BRIEF.md
# Fixed-Point Multiplier with Round/Truncate Quantizer

This block multiplies two signed two's-complement fixed-point operands. Each operand is `DW` bits wide and has `FW` fraction bits. The full-precision product has `2*DW` bits and `2*FW` fraction bits. It is brought back to `FW` fraction bits by one of two methods, chosen by a mode input:

- **Truncation** drops the low bits, which rounds toward minus infinity.
- **Round-to-nearest** adds half of the new LSB before the low bits are dropped.

After quantization only the low `DW` bits are kept. An out-of-range product therefore wraps around rather than clamping. For example, -1 × -1 gives -1 in the default Q1.3 format.

A second path, the reducer, quantizes a wider fixed-point word. Its input is `RW` bits wide with `RF` fraction bits. Its output has `RQF` fraction bits and keeps every integer bit, so it is `RW-(RF-RQF)` bits wide. It uses the same two modes. If rounding carries past the top integer bit, the result wraps.

Both paths share one input strobe and one mode bit. The operands, the reducer word and the mode are captured together when `in_vld` is high. The results appear on registered outputs one clock later, with `out_vld` high for that cycle. The outputs hold their value while no strobe arrives.

Top module: `fxq_mul_round`

## Requirements
- R1: While `rst` is high at a rising edge, `out_vld`, `prod_q` and `red_q` are all cleared to zero on that edge.
- R2: `out_vld` is high in the cycle right after a cycle with `in_vld` high, and low otherwise. When `in_vld` is low, `prod_q` and `red_q` keep their values.
- R3: With `rnd_mode`=0 (truncate), `prod_q` equals the low `DW` bits of floor(a·b·2^FW). Here a and b are the signed operand values scaled by 2^-FW.
- R4: With `rnd_mode`=1 (round), `prod_q` equals the low `DW` bits of floor(a·b·2^FW + 0.5). An exact half-LSB tie rounds upward, toward plus infinity, for both positive and negative products.
- R5: A product outside the output range wraps modulo 2^DW and never saturates. With DW=4 and FW=3, the inputs -1 (1000) × -1 (1000) give 1000 in both modes.
- R6: The reducer output `red_q` is the low `RW-(RF-RQF)` bits of floor(r·2^RQF) when `rnd_mode`=0, and of floor(r·2^RQF + 0.5) when `rnd_mode`=1. Here r is `red_in` scaled by 2^-RF. Examples with 7-bit Q2.5 input and 3 output fraction bits:
  - 0001110 gives 00100 when rounded and 00011 when truncated.
  - 1000110 gives 10010 when rounded and 10001 when truncated.
  - 1101000 gives 11010 in both modes.
- R7: If rounding carries the reducer result past its top integer bit, the result wraps. With the default sizes, 0111111 rounds to 10000 and truncates to 01111.
- R8: `rnd_mode` is sampled only together with a strobe. Changing it while `in_vld` is low leaves both outputs unchanged.
- R9: When the dropped low bits are all zero, both paths give the same result in both modes, equal to the exact value. In particular, a zero operand gives `prod_q`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Input strobe; captures operands, reducer word and mode |
| rnd_mode | input | 1 | 1 = round to nearest, 0 = truncate |
| op_a | input | DW | Multiplicand, signed, FW fraction bits |
| op_b | input | DW | Multiplier, signed, FW fraction bits |
| red_in | input | RW | Reducer input, signed, RF fraction bits |
| out_vld | output | 1 | High one cycle after a strobe |
| prod_q | output | DW | Quantized, wrapped product |
| red_q | output | RW-(RF-RQF) | Quantized reducer result |

## Verification
The multiplier is swept over every operand pair of the default Q1.3 format in both modes. Each result is compared with a floor-based model, so any bias in the rounding constant or a wrong slice position shows up.

Some patterns are picked for the cases they separate:
- Half-LSB ties of both signs tell round-half-up apart from round-away-from-zero.
- A tiny negative product tells floor apart from truncation toward zero.
- The corner -1 × -1 tells wrap-around apart from saturation.

The reducer is driven with the worked Q2.5 examples and with a carry-out case that must wrap. Mode changes between strobes show that the mode is captured only together with the operands.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
  typedef enum logic {
    QM_TRUNC = 1'b0,
    QM_ROUND = 1'b1
  } qmode_e;
endpackage

// File: rtl/fxq_smul.sv
module fxq_smul #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  logic signed [2*W-1:0] prod_s;

  assign prod_s = $signed(a) * $signed(b);
  assign p      = prod_s;
endmodule

// File: rtl/fxq_quant.sv
module fxq_quant
  import fxq_pkg::*;
#(
  parameter int IW = 8,
  parameter int IF = 6,
  parameter int OF = 3,
  parameter int OW = 4
) (
  input  logic [IW-1:0] x,
  input  qmode_e        mode,
  output logic [OW-1:0] y
);
  localparam int SH = IF - OF;
  localparam int EW = IW + 1;

  generate
    if (SH > 0) begin : g_shift
      localparam logic [EW-1:0] HALF = EW'(1) << (SH - 1);
      logic signed [EW-1:0] ext;
      logic signed [EW-1:0] sum;
      logic signed [EW-1:0] shr;

      // one guard bit so the half-LSB add cannot overflow
      assign ext = {x[IW-1], x};
      assign sum = ext + ((mode == QM_ROUND) ? HALF : '0);
      assign shr = sum >>> SH;
      assign y   = shr[OW-1:0];
    end else begin : g_pass
      assign y = x[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/fxq_mul_round.sv
module fxq_mul_round
  import fxq_pkg::*;
#(
  parameter int DW  = 4,
  parameter int FW  = 3,
  parameter int RW  = 7,
  parameter int RF  = 5,
  parameter int RQF = 3,
  localparam int PW  = 2 * DW,
  localparam int ROW = RW - (RF - RQF)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_vld,
  input  logic           rnd_mode,
  input  logic [DW-1:0]  op_a,
  input  logic [DW-1:0]  op_b,
  input  logic [RW-1:0]  red_in,
  output logic           out_vld,
  output logic [DW-1:0]  prod_q,
  output logic [ROW-1:0] red_q
);
  logic [PW-1:0]  prod_full;
  logic [DW-1:0]  prod_n;
  logic [ROW-1:0] red_n;
  qmode_e         mode;

  assign mode = qmode_e'(rnd_mode);

  fxq_smul #(.W(DW)) u_mul (
    .a (op_a),
    .b (op_b),
    .p (prod_full)
  );

  fxq_quant #(.IW(PW), .IF(2 * FW), .OF(FW), .OW(DW)) u_qprod (
    .x    (prod_full),
    .mode (mode),
    .y    (prod_n)
  );

  fxq_quant #(.IW(RW), .IF(RF), .OF(RQF), .OW(ROW)) u_qred (
    .x    (red_in),
    .mode (mode),
    .y    (red_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      prod_q  <= '0;
      red_q   <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        prod_q <= prod_n;
        red_q  <= red_n;
      end
    end
  end
endmodule

// File: rtl/fxq_mul_round_chk.sv
module fxq_mul_round_chk #(
  parameter int DW  = 4,
  parameter int RW  = 7,
  parameter int RF  = 5,
  parameter int RQF = 3,
  localparam int SH  = RF - RQF,
  localparam int ROW = RW - SH
) (
  input logic           clk,
  input logic           rst,
  input logic           in_vld,
  input logic [DW-1:0]  op_a,
  input logic [DW-1:0]  op_b,
  input logic [RW-1:0]  red_in,
  input logic           out_vld,
  input logic [DW-1:0]  prod_q,
  input logic [ROW-1:0] red_q
);
  localparam logic [DW-1:0] MINV = {1'b1, {(DW-1){1'b0}}};

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && prod_q == '0 && red_q == '0));

  // R2
  vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  // R2
  vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld);

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(prod_q) && $stable(red_q)));

  // R5
  wrap_min_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && op_a == MINV && op_b == MINV) |=> (prod_q == MINV));

  // R9
  zero_op_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && (op_a == '0 || op_b == '0)) |=> (prod_q == '0));

  // R9
  exact_red_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && red_in[SH-1:0] == '0) |=> (red_q == $past(red_in[RW-1:SH])));
endmodule

bind fxq_mul_round fxq_mul_round_chk #(
  .DW(DW), .RW(RW), .RF(RF), .RQF(RQF)
) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
  .red_in(red_in), .out_vld(out_vld), .prod_q(prod_q), .red_q(red_q)
);

// File: tb/sim_fxq_mul_round.sv
`timescale 1ns/1ps
module sim_fxq_mul_round;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_vld = 1'b0;
  logic       rnd_mode = 1'b0;
  logic [3:0] op_a = '0;
  logic [3:0] op_b = '0;
  logic [6:0] red_in = '0;
  logic       out_vld;
  logic [3:0] prod_q;
  logic [4:0] red_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fxq_mul_round u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .rnd_mode(rnd_mode),
    .op_a(op_a), .op_b(op_b), .red_in(red_in),
    .out_vld(out_vld), .prod_q(prod_q), .red_q(red_q)
  );

  // floor(v / 2^sh), optionally after adding half of the new LSB
  function automatic int qmodel(int v, int sh, bit rnd);
    int t;
    t = v + (rnd ? (1 << (sh - 1)) : 0);
    return t >>> sh;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(logic [3:0] a, logic [3:0] b, logic [6:0] r, logic m);
    @(negedge clk);
    op_a = a; op_b = b; red_in = r; rnd_mode = m; in_vld = 1'b1;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 out_vld", int'(out_vld), 0);
    chk("R1 prod_q", int'(prod_q), 0);
    chk("R1 red_q", int'(red_q), 0);
  endtask

  task automatic t_examples();
    strobe(4'b1000, 4'b0111, 7'd0, 1'b1);
    chk("R4 -1*0.875", int'(prod_q), 4'b1001);
    chk("R2 out_vld", int'(out_vld), 1);
    strobe(4'b0111, 4'b0111, 7'd0, 1'b1);
    chk("R4 0.875^2", int'(prod_q), 4'b0110);
    strobe(4'b1000, 4'b1000, 7'd0, 1'b1);
    chk("R5 -1*-1 round", int'(prod_q), 4'b1000);
    strobe(4'b1000, 4'b1000, 7'd0, 1'b0);
    chk("R5 -1*-1 trunc", int'(prod_q), 4'b1000);
    strobe(4'b0001, 4'b1111, 7'd0, 1'b0);
    chk("R3 tiny negative floors", int'(prod_q), 4'b1111);
    strobe(4'b0001, 4'b1111, 7'd0, 1'b1);
    chk("R4 tiny negative rounds to 0", int'(prod_q), 4'b0000);
    strobe(4'b0100, 4'b0011, 7'd0, 1'b1);
    chk("R4 positive tie up", int'(prod_q), 4'b0010);
    strobe(4'b1100, 4'b0011, 7'd0, 1'b1);
    chk("R4 negative tie up", int'(prod_q), 4'b1111);
    strobe(4'b1100, 4'b0011, 7'd0, 1'b0);
    chk("R3 negative tie trunc", int'(prod_q), 4'b1110);
    strobe(4'b0000, 4'b1011, 7'd0, 1'b1);
    chk("R9 zero operand", int'(prod_q), 0);
  endtask

  task automatic t_sweep();
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          int sa, sb, e;
          sa = (a >= 8) ? a - 16 : a;
          sb = (b >= 8) ? b - 16 : b;
          e = qmodel(sa * sb, 3, m[0]) & 15;
          strobe(4'(a), 4'(b), 7'd0, m[0]);
          chk(m ? "R4 sweep" : "R3 sweep", int'(prod_q), e);
        end
  endtask

  task automatic t_reducer();
    strobe(4'd0, 4'd0, 7'b0001110, 1'b1);
    chk("R6 00.01110 round", int'(red_q), 5'b00100);
    strobe(4'd0, 4'd0, 7'b0001110, 1'b0);
    chk("R6 00.01110 trunc", int'(red_q), 5'b00011);
    strobe(4'd0, 4'd0, 7'b1000110, 1'b1);
    chk("R6 10.00110 round", int'(red_q), 5'b10010);
    strobe(4'd0, 4'd0, 7'b1000110, 1'b0);
    chk("R6 10.00110 trunc", int'(red_q), 5'b10001);
    strobe(4'd0, 4'd0, 7'b1101000, 1'b1);
    chk("R6 11.01000 round", int'(red_q), 5'b11010);
    strobe(4'd0, 4'd0, 7'b1101000, 1'b0);
    chk("R6 11.01000 trunc", int'(red_q), 5'b11010);
    strobe(4'd0, 4'd0, 7'b0111111, 1'b1);
    chk("R7 carry wraps", int'(red_q), 5'b10000);
    strobe(4'd0, 4'd0, 7'b0111111, 1'b0);
    chk("R7 trunc no carry", int'(red_q), 5'b01111);
    strobe(4'd0, 4'd0, 7'b1010100, 1'b1);
    chk("R9 exact reducer", int'(red_q), 5'b10101);
  endtask

  task automatic t_hold();
    strobe(4'b0100, 4'b0011, 7'b0001110, 1'b0);
    chk("R3 hold setup prod", int'(prod_q), 4'b0001);
    @(negedge clk);
    rnd_mode = 1'b1; op_a = 4'b0111; red_in = 7'b0111111;
    @(negedge clk);
    @(negedge clk);
    chk("R8 prod held", int'(prod_q), 4'b0001);
    chk("R8 red held", int'(red_q), 5'b00011);
    chk("R2 out_vld idle", int'(out_vld), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_examples();
    t_sweep();
    t_reducer();
    t_hold();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule